// File: doc/BRIEF.md
# Upper-Memory Shadow Routing Decoder

This block is the configuration and decode unit of an older PC chipset. Software programs it through two I/O ports. A write to the index port selects one of 256 byte-wide configuration registers. The data port then reads or writes the selected register. Three of these registers set how the 256 KB area from 0xC0000 to 0xFFFFF is handled. For each memory address presented, the block reports whether the access goes to internal DRAM, goes to the external bus, or is blocked.

The area from 0xC0000 to 0xEFFFF is split into three 64 KB segments, each made of four 16 KB blocks. A segment enable bit and a per-block bit must both be set before a block is shadowed. A shared write-policy bit decides whether writes to shadowed blocks reach DRAM. The top 64 KB segment follows its own two-state policy, chosen by a single bit. Writing the wait-state register produces a one-cycle request pulse for a neighbouring timing unit.

Top module: `shadow_route_dec`

## Requirements
- R1: A write to I/O port 0x22 latches an 8-bit register index. A write to I/O port 0x24 stores the data byte in the indexed register. A read of port 0x24 with `io_rd` high returns that register. Writes to other registers leave it unchanged.
- R2: `io_rdata` is 0xFF whenever the port being read is not 0x24, and whenever `io_rd` is low.
- R3: After reset, register 0x10 reads 0x3F, register 0x11 reads 0xF0, and every other register reads 0x00.
- R4: In the segment 0xF0000–0xFFFFF, when bit 7 of register 0x11 is 0, reads go to DRAM and writes are blocked. When bit 7 is 1, reads go to the external bus and writes go to DRAM.
- R5: Bits 4, 5 and 6 of register 0x11 enable segments 0xC, 0xD and 0xE. While a segment's enable bit is 0, every read and write in that segment goes to the external bus.
- R6: In a shadowed block, reads go to DRAM. Writes go to DRAM when bit 3 of register 0x11 is 1, and to the external bus when it is 0.
- R7: Block bits follow ascending address order within each segment. For segment 0xC they are bits 4..7 of register 0x13. For segment 0xD they are bits 0..3 of register 0x12. For segment 0xE they are bits 4..7 of register 0x12.
- R8: A block whose own bit is 0 routes reads and writes to the external bus, even when its segment is enabled.
- R9: For addresses below 0xC0000, `in_window` and all three route outputs are 0.
- R10: A data-port write to register 0x10 makes `wait_upd` high for exactly the one cycle after the write edge. Writes to other registers do not raise it.
- R11: Inside the window (0xC0000 and above), exactly one of `route_dram`, `route_ext` and `route_block` is high.
- R12: The decode is combinational from the current register contents. A register write changes the routing as soon as the clock edge that captures it has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, sampled at the clock edge |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | I/O read data |
| mem_addr | input | 20 | Memory address being decoded |
| mem_we | input | 1 | 1 for a write access, 0 for a read |
| in_window | output | 1 | Address lies in 0xC0000–0xFFFFF |
| route_dram | output | 1 | Access goes to internal DRAM |
| route_ext | output | 1 | Access goes to the external bus |
| route_block | output | 1 | Access is blocked |
| wait_upd | output | 1 | One-cycle wait-state update request |

## Verification
The hardest case to reach is a block whose own bit is set while its segment enable is clear, because the reset value enables every segment and clears every block bit. The stimulus first sets single block bits in registers 0x12 and 0x13 with all segments enabled. It then clears individual segment enables in register 0x11 and probes those same blocks. This shows that the block bit alone never shadows a block. The probes move one 16 KB step at a time through each segment, so a block mapping that is wrong by one position shows up.

// File: rtl/shadow_route_dec.sv
module shadow_route_dec #(
  parameter int          IO_AW     = 16,
  parameter int          MEM_AW    = 20,
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_we,
  output logic              in_window,
  output logic              route_dram,
  output logic              route_ext,
  output logic              route_block,
  output logic              wait_upd
);
  localparam int          NREG     = 256;
  localparam logic [7:0]  REG_WAIT = 8'h10;
  localparam logic [7:0]  REG_CTRL = 8'h11;
  localparam logic [7:0]  REG_DE   = 8'h12;
  localparam logic [7:0]  REG_C    = 8'h13;
  localparam logic [7:0]  RST_WAIT = 8'h3F;
  localparam logic [7:0]  RST_CTRL = 8'hF0;

  logic [7:0] idx;
  logic [7:0] cfg [NREG];

  wire wr_idx  = io_wr && (io_addr == IO_AW'(IDX_PORT));
  wire wr_data = io_wr && (io_addr == IO_AW'(DATA_PORT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      wait_upd <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        if (8'(i) == REG_WAIT)      cfg[i] <= RST_WAIT;
        else if (8'(i) == REG_CTRL) cfg[i] <= RST_CTRL;
        else                        cfg[i] <= '0;
      end
    end else begin
      wait_upd <= wr_data && (idx == REG_WAIT);
      if (wr_idx)  idx      <= io_wdata;
      if (wr_data) cfg[idx] <= io_wdata;
    end
  end

  assign io_rdata = (io_rd && io_addr == IO_AW'(DATA_PORT)) ? cfg[idx] : 8'hFF;

  // decode of the upper 256 KB
  wire [3:0] seg  = mem_addr[MEM_AW-1 -: 4];
  wire [1:0] blk  = mem_addr[MEM_AW-5 -: 2];
  wire [7:0] ctrl = cfg[REG_CTRL];
  wire [11:0] blk_map = {cfg[REG_DE], cfg[REG_C][7:4]};

  logic seg_en, shadowed;

  always_comb begin
    seg_en      = ctrl[3'd4 + {1'b0, seg[1:0]}];
    shadowed    = seg_en && blk_map[{seg[1:0], blk}];
    in_window   = (seg[3:2] == 2'b11);
    route_dram  = 1'b0;
    route_ext   = 1'b0;
    route_block = 1'b0;
    if (in_window) begin
      if (seg[1:0] == 2'b11) begin
        if (ctrl[7]) begin
          route_ext  = !mem_we;
          route_dram = mem_we;
        end else begin
          route_dram  = !mem_we;
          route_block = mem_we;
        end
      end else if (shadowed) begin
        if (!mem_we || ctrl[3]) route_dram = 1'b1;
        else                    route_ext  = 1'b1;
      end else begin
        route_ext = 1'b1;
      end
    end
  end
endmodule

module shadow_route_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_wr,
  input logic [7:0]  io_rdata,
  input logic [19:0] mem_addr,
  input logic        mem_we,
  input logic        in_window,
  input logic        route_dram,
  input logic        route_ext,
  input logic        route_block,
  input logic        wait_upd
);
  p_one_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> $countones({route_dram, route_ext, route_block}) == 1);

  p_quiet_below_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[19:18] != 2'b11) |-> !(in_window || route_dram || route_ext || route_block));

  p_top_read_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[19:16] == 4'hF && !mem_we) |-> !route_block);

  p_no_block_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[19:18] == 2'b11 && mem_addr[17:16] != 2'b11) |-> !route_block);

  p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wait_upd |-> $past(io_wr && io_addr == 16'h0024));

  p_idle_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != 16'h0024) |-> io_rdata == 8'hFF);
endmodule

bind shadow_route_dec shadow_route_dec_chk chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
  .io_rdata(io_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
  .in_window(in_window), .route_dram(route_dram), .route_ext(route_ext),
  .route_block(route_block), .wait_upd(wait_upd)
);

// File: tb/shadow_route_dec_test.sv
module shadow_route_dec_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr = '0;
  logic        mem_we = 0;
  logic        in_window, route_dram, route_ext, route_block, wait_upd;

  int checks = 0, fails = 0;
  bit done = 0;

  // encodings of the expected route vector {in_window, dram, ext, block}
  localparam logic [3:0] DRAM = 4'b1100, EXT = 4'b1010, BLK = 4'b1001, NONE = 4'b0000;

  shadow_route_dec uut (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] port, logic [7:0] d);
    @(negedge clk);
    io_addr = port; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0; io_addr = 16'h0080;
  endtask

  task automatic wr_reg(logic [7:0] r, logic [7:0] d);
    io_write(16'h0022, r);
    io_write(16'h0024, d);
  endtask

  task automatic rd_port(logic [15:0] port, output logic [7:0] d);
    @(negedge clk);
    io_addr = port; io_rd = 1;
    #1 d = io_rdata;
    io_rd = 0; io_addr = 16'h0080;
  endtask

  task automatic rd_reg(logic [7:0] r, output logic [7:0] d);
    io_write(16'h0022, r);
    rd_port(16'h0024, d);
  endtask

  task automatic route(string tag, logic [19:0] a, logic we, logic [3:0] exp);
    mem_addr = a; mem_we = we;
    #1 chk(tag, {4'b0, in_window, route_dram, route_ext, route_block}, {4'b0, exp});
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_reg(8'h10, d); chk("R3 reg10", d, 8'h3F);
    rd_reg(8'h11, d); chk("R3 reg11", d, 8'hF0);
    rd_reg(8'h12, d); chk("R3 reg12", d, 8'h00);
    rd_reg(8'h13, d); chk("R3 reg13", d, 8'h00);
    rd_reg(8'h77, d); chk("R3 reg77", d, 8'h00);
    route("R4 reset top read", 20'hF0000, 0, EXT);
    route("R4 reset top write", 20'hFFFFF, 1, DRAM);
    route("R8 reset C read", 20'hC0000, 0, EXT);
    route("R8 reset E write", 20'hEC000, 1, EXT);
  endtask

  task automatic t_ports;
    logic [7:0] d;
    rd_port(16'h0022, d); chk("R2 index port read", d, 8'hFF);
    rd_port(16'h0080, d); chk("R2 other port read", d, 8'hFF);
    io_addr = 16'h0024; #1 chk("R2 data port no strobe", io_rdata, 8'hFF);
    io_addr = 16'h0080;
  endtask

  task automatic t_index_rw;
    logic [7:0] d;
    wr_reg(8'h55, 8'hA5);
    wr_reg(8'h56, 8'h3C);
    rd_reg(8'h55, d); chk("R1 reg55", d, 8'hA5);
    rd_reg(8'h56, d); chk("R1 reg56", d, 8'h3C);
  endtask

  task automatic t_top_policy;
    wr_reg(8'h11, 8'h70);
    // R12: checked right after the write edge
    route("R12 R4 top read dram", 20'hF8000, 0, DRAM);
    route("R4 top write blocked", 20'hF8000, 1, BLK);
    route("R11 single route", 20'hF0000, 1, BLK);
  endtask

  task automatic t_block_map;
    wr_reg(8'h11, 8'h78);
    wr_reg(8'h13, 8'h20);
    route("R7 C blk0", 20'hC0000, 0, EXT);
    route("R7 C blk1", 20'hC4000, 0, DRAM);
    route("R7 C blk2", 20'hC8000, 0, EXT);
    route("R6 C blk1 write dram", 20'hC7FFF, 1, DRAM);
    wr_reg(8'h12, 8'h81);
    route("R7 D blk0", 20'hD0000, 0, DRAM);
    route("R7 D blk1", 20'hD4000, 0, EXT);
    route("R7 E blk3", 20'hEC000, 0, DRAM);
    route("R7 E blk0", 20'hE0000, 0, EXT);
    route("R8 D blk3 unset", 20'hDC000, 1, EXT);
    wr_reg(8'h11, 8'h70);
    route("R6 write ext when bit3 clear", 20'hC4000, 1, EXT);
    route("R6 read dram when bit3 clear", 20'hC4000, 0, DRAM);
  endtask

  task automatic t_seg_disable;
    wr_reg(8'h11, 8'h68);
    route("R5 C disabled read", 20'hC4000, 0, EXT);
    route("R5 C disabled write", 20'hC4000, 1, EXT);
    route("R5 D enabled", 20'hD0000, 0, DRAM);
    wr_reg(8'h11, 8'h08);
    route("R5 E disabled", 20'hEC000, 0, EXT);
    route("R5 D disabled", 20'hD0000, 1, EXT);
  endtask

  task automatic t_low;
    route("R9 below window", 20'hBFFFF, 0, NONE);
    route("R9 zero write", 20'h00000, 1, NONE);
    route("R9 A0000", 20'hA0000, 0, NONE);
  endtask

  task automatic t_pulse;
    wr_reg(8'h10, 8'h12);
    #1 chk("R10 pulse high", {7'b0, wait_upd}, 8'h01);
    @(negedge clk); #1 chk("R10 pulse one cycle", {7'b0, wait_upd}, 8'h00);
    wr_reg(8'h13, 8'h00);
    #1 chk("R10 no pulse other reg", {7'b0, wait_upd}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R10 reset pulse low", {7'b0, wait_upd}, 8'h00);
    rst_n = 1;
    t_reset;
    t_ports;
    t_index_rw;
    t_top_policy;
    t_block_map;
    t_seg_disable;
    t_low;
    t_pulse;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule